// File: doc/BRIEF.md
# Trigger Selector with Edge Detection

This block routes event lines to trigger outputs. Each output channel has its own group of five candidate event lines. A 3-bit selector picks one of them. The chosen line is either passed through as a level or turned into a one-clock pulse on its rising or falling edge. A per-channel enable then gates the result onto a registered output. Typical sources are timer compare-match requests and a PWM event. The outputs feed a consumer such as a transfer engine.

Each channel is set up through an 8-bit field. Four such fields are packed into each 32-bit control word. The words sit on a single-cycle register bus with write enable, a word address and 32-bit data. Reads are combinational and return the addressed word.

Top module: `trig_select`

## Requirements
- R1: After reset every configuration field is 0, every control word reads as 0 and every trigger output is 0.
- R2: Channel `4*w+k` is configured by bits `8k+7:8k` of word `w`. Within a field, bits 6:4 are the selector, bit 2 is the polarity, bit 1 is the mode and bit 0 is the enable. Bits 7 and 3 of every field ignore writes and read as 0.
- R3: Selector codes 0 to 3 choose event lines 0 to 3 of that channel's five-line group (`src_i[5c+4:5c]`).
- R4: Selector code 4 chooses line 4 only on channels whose bit is set in `PWM_MASK` (channels 2 and 6 by default). On every other channel code 4 is reserved, and codes 5 to 7 are reserved on all channels. A reserved code selects a constant 0, so in level mode the output stays 0.
- R5: With mode 0, the output in the cycle after a clock edge equals enable AND the selected line sampled at that edge. The delay is one clock.
- R6: With mode 1 and polarity 0, the output is a one-clock pulse. It is 1 in the cycle after the selected line is found 1 at an edge where it had been 0 at the previous edge.
- R7: With mode 1 and polarity 1, the pulse fires instead on a change from 1 to 0.
- R8: With the enable at 0 the output is 0 in the next cycle. The edge history keeps tracking the selected line while the channel is disabled, so enabling a channel whose line is held steady creates no pulse.
- R9: Word addresses at or above `NUM_WORDS` read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| src_i | input | 5*4*NUM_WORDS | Five event lines per channel |
| trig_o | output | 4*NUM_WORDS | Registered trigger outputs |

## Verification
Some properties are checked on every cycle. Reserved read bits are always 0, and unmapped addresses read as 0. A disabled channel produces no output in the next cycle. A reserved selector in level mode gives a silent output. An edge-mode pulse never lasts two cycles while the settings stay fixed.

Other behaviour shows only in the bench scenarios, checked against the bench's cycle model. These cover the mapping of each selector code to its line and the restriction of code 4 to the PWM channels. They also cover the exact one-clock latency and which edge polarity fires. Finally, they show that no pulse appears when a channel is enabled on a steady line.

// File: rtl/trig_select.sv
module trig_select #(
  parameter int          NUM_WORDS = 2,
  parameter int          AW        = 4,
  parameter logic [63:0] PWM_MASK  = 64'h44
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [AW-1:0]              bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [5*4*NUM_WORDS-1:0]   src_i,
  output logic [4*NUM_WORDS-1:0]     trig_o
);
  localparam int NUM_CH = 4 * NUM_WORDS;

  logic [3*NUM_CH-1:0] sel_q;
  logic [NUM_CH-1:0]   pol_q, mode_q, en_q, hist_q;
  logic [NUM_CH-1:0]   pick, edg, pre;
  logic                unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      en_q   <= '0;
    end else if (bus_we) begin
      for (int c = 0; c < NUM_CH; c++)
        if (bus_addr == AW'(c / 4)) begin
          sel_q[3*c +: 3] <= bus_wdata[8*(c%4)+4 +: 3];
          pol_q[c]        <= bus_wdata[8*(c%4)+2];
          mode_q[c]       <= bus_wdata[8*(c%4)+1];
          en_q[c]         <= bus_wdata[8*(c%4)];
        end
    end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pick
    logic [4:0] lines;
    assign lines = src_i[5*c +: 5];
    always_comb
      case (sel_q[3*c +: 3])
        3'd0:    pick[c] = lines[0];
        3'd1:    pick[c] = lines[1];
        3'd2:    pick[c] = lines[2];
        3'd3:    pick[c] = lines[3];
        3'd4:    pick[c] = PWM_MASK[c] & lines[4];
        default: pick[c] = 1'b0;
      endcase
  end

  assign edg = (pol_q & hist_q & ~pick) | (~pol_q & ~hist_q & pick);
  assign pre = (mode_q & edg) | (~mode_q & pick);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist_q <= '0;
      trig_o <= '0;
    end else begin
      hist_q <= pick;
      trig_o <= en_q & pre;
    end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == AW'(c / 4))
        bus_rdata[8*(c%4) +: 8] = {1'b0, sel_q[3*c +: 3], 1'b0, pol_q[c], mode_q[c], en_q[c]};
  end
endmodule

module trig_select_chk #(
  parameter int          NUM_WORDS = 2,
  parameter int          AW        = 4,
  parameter logic [63:0] PWM_MASK  = 64'h44
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_rdata,
  input logic [4*NUM_WORDS-1:0]     trig_o,
  input logic [3*4*NUM_WORDS-1:0]   sel_q,
  input logic [4*NUM_WORDS-1:0]     pol_q,
  input logic [4*NUM_WORDS-1:0]     mode_q,
  input logic [4*NUM_WORDS-1:0]     en_q
);
  localparam int NUM_CH = 4 * NUM_WORDS;

  // R9
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= NUM_WORDS) |-> (bus_rdata == 32'h0));

  for (genvar k = 0; k < 4; k++) begin : g_fld
    // R2
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[8*k+7] == 1'b0) && (bus_rdata[8*k+3] == 1'b0));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rsv;
    assign rsv = (sel_q[3*c +: 3] > 3'd4) || (sel_q[3*c +: 3] == 3'd4 && !PWM_MASK[c]);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |=> !trig_o[c]);

    // R4
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv && !mode_q[c]) |=> !trig_o[c]);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[c] && $past(mode_q[c]) && $stable(pol_q[c]) && trig_o[c]) |=> !trig_o[c]);
  end
endmodule

bind trig_select trig_select_chk #(.NUM_WORDS(NUM_WORDS), .AW(AW), .PWM_MASK(PWM_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .trig_o(trig_o),
  .sel_q(sel_q), .pol_q(pol_q), .mode_q(mode_q), .en_q(en_q));

// File: tb/sim_trig_select.sv
`timescale 1ns/1ps
module sim_trig_select;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [39:0] src_i = 0;
  logic [7:0]  trig_o;

  trig_select u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .trig_o(trig_o));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  int msel[8], mpol[8], mmode[8], men[8], mhist[8];
  logic [7:0] mtrig = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic bit mpick(int c);
    int s = msel[c];
    if (s < 4) return src_i[5*c+s];
    if (s == 4 && (c == 2 || c == 6)) return src_i[5*c+4];
    return 0;
  endfunction

  function automatic logic [31:0] mread(int a);
    logic [31:0] r = 0;
    if (a < 2)
      for (int k = 0; k < 4; k++) begin
        int c = 4*a + k;
        r[8*k +: 8] = 8'((msel[c] << 4) | (mpol[c] << 2) | (mmode[c] << 1) | men[c]);
      end
    return r;
  endfunction

  task automatic tick();
    logic [7:0] s, nt;
    for (int c = 0; c < 8; c++) begin
      bit e;
      s[c] = mpick(c);
      e = mpol[c] ? (mhist[c] == 1 && !s[c]) : (mhist[c] == 0 && s[c]);
      nt[c] = (men[c] != 0) && (mmode[c] ? e : s[c]);
    end
    @(posedge clk); #1;
    for (int c = 0; c < 8; c++) mhist[c] = s[c];
    if (bus_we && bus_addr < 2)
      for (int k = 0; k < 4; k++) begin
        int c = 4*int'(bus_addr) + k;
        msel[c] = int'(bus_wdata[8*k+4 +: 3]);
        mpol[c] = int'(bus_wdata[8*k+2]);
        mmode[c] = int'(bus_wdata[8*k+1]);
        men[c] = int'(bus_wdata[8*k]);
      end
    mtrig = nt;
    chk(trig_o === mtrig, tag, 32'(trig_o), 32'(mtrig));
    chk(bus_rdata === mread(int'(bus_addr)), tag, bus_rdata, mread(int'(bus_addr)));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    tick();
    bus_we = 0;
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      src_i = {lfsr[7:0], lfsr} ^ {lfsr[31:24], lfsr[15:0], lfsr[31:16]};
      tick();
    end
  endtask

  function automatic logic [31:0] fill(int sel, int pol, int mode, int en);
    logic [7:0] b = 8'((sel << 4) | (pol << 2) | (mode << 1) | en);
    return {b, b, b, b};
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    for (int c = 0; c < 8; c++) begin msel[c]=0; mpol[c]=0; mmode[c]=0; men[c]=0; mhist[c]=0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    tag = "R1";
    chk(trig_o === 8'h0, "R1", 32'(trig_o), 0);
    chk(bus_rdata === 32'h0, "R1", bus_rdata, 0);
    bus_addr = 1; #1;
    chk(bus_rdata === 32'h0, "R1", bus_rdata, 0);
    tick();

    // R2 field layout and reserved bits
    tag = "R2";
    wr(0, 32'hFFFF_FFFF); tick();
    chk(bus_rdata === 32'h7777_7777, "R2", bus_rdata, 32'h7777_7777);
    wr(1, 32'h5A3C_961E); tick();
    chk(bus_rdata === 32'h5234_1616, "R2", bus_rdata, 32'h5234_1616);

    // R9 unmapped address
    tag = "R9";
    wr(3, 32'hFFFF_FFFF); tick();
    chk(bus_rdata === 32'h0, "R9", bus_rdata, 0);
    bus_addr = 0; #1;
    chk(bus_rdata === 32'h7777_7777, "R9", bus_rdata, 32'h7777_7777);
    bus_addr = 1; #1;
    chk(bus_rdata === 32'h5234_1616, "R9", bus_rdata, 32'h5234_1616);

    // R5 one-clock latency, level mode
    tag = "R5";
    wr(0, fill(0, 0, 0, 1)); wr(1, fill(0, 0, 0, 1));
    src_i = 0; tick(); tick();
    src_i[0] = 1; #1;
    chk(trig_o[0] === 1'b0, "R5", 32'(trig_o[0]), 0);
    tick();
    chk(trig_o[0] === 1'b1, "R5", 32'(trig_o[0]), 1);
    traffic(100);

    // R3 each code on each channel
    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      wr(0, fill(s, 0, 0, 1)); wr(1, fill(s, 0, 0, 1));
      traffic(60);
    end

    // R4 code 4 and reserved codes
    tag = "R4";
    for (int s = 4; s < 8; s++) begin
      wr(0, fill(s, 0, 0, 1)); wr(1, fill(s, 0, 0, 1));
      traffic(60);
    end
    wr(0, fill(5, 0, 0, 1)); src_i = '1; tick(); tick();
    chk(trig_o[3:0] === 4'h0, "R4", 32'(trig_o), 0);

    // R6 rising edge pulses
    tag = "R6";
    wr(0, fill(1, 0, 1, 1)); wr(1, fill(4, 0, 1, 1));
    traffic(200);
    src_i = 0; tick(); tick();
    src_i[1] = 1; tick();
    chk(trig_o[0] === 1'b1, "R6", 32'(trig_o[0]), 1);
    tick();
    chk(trig_o[0] === 1'b0, "R6", 32'(trig_o[0]), 0);

    // R7 falling edge pulses
    tag = "R7";
    wr(0, fill(2, 1, 1, 1)); wr(1, fill(3, 1, 1, 1));
    traffic(200);
    src_i = '1; tick(); tick();
    src_i[2] = 0; tick();
    chk(trig_o[0] === 1'b1, "R7", 32'(trig_o[0]), 1);
    tick();
    chk(trig_o[0] === 1'b0, "R7", 32'(trig_o[0]), 0);

    // R8 disable and no false edge when enabling
    tag = "R8";
    wr(0, fill(0, 0, 1, 0)); wr(1, fill(0, 0, 0, 0));
    traffic(100);
    src_i = '1; tick(); tick();
    wr(0, fill(0, 0, 1, 1));
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(trig_o[3:0] === 4'h0, "R8", 32'(trig_o), 0);
    end
    traffic(100);

    finish_up();
  end
endmodule